// File: doc/BRIEF.md
# DMA Channel Register and Interrupt Interface

This block is the software-visible face of a multi-channel memory-to-memory DMA controller. Each channel owns a 4 KB window. Inside that window sit a control word, a staged "next" descriptor and a read-only "executing" copy of that descriptor. The staged descriptor holds a configuration word, a 64-bit byte count, a 64-bit destination and a 64-bit source. Software programs the staged descriptor and then writes the control word with the run bit set. That write copies the staged descriptor into the executing set and sends a one-cycle start request to the channel's engine, which moves the data and lies outside this block.

The engine reports completion or failure with single-cycle pulses. Each pulse sets the matching status bit in the control word and clears the run bit. Every channel drives two level interrupts. Each interrupt is high while its status bit and its enable bit, both held in the control word, are set.

Access uses a 32-bit request port with valid and ready. The block is always ready, and read data returns one cycle after the read is accepted. Each 64-bit register is reached as a low word at its offset and a high word at the offset plus 4.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register of every channel reads as zero, all interrupt outputs are low and no start request is active.
- R2: The staged config (offset 0x004) and the low/high words of the staged byte count (0x008/0x00C), destination (0x010/0x014) and source (0x018/0x01C) read back the last value written.
- R3: The executing registers (config 0x104, byte count 0x108/0x10C, destination 0x110/0x114, source 0x118/0x11C) are read-only. Writes to them are discarded and they change only when a transfer starts.
- R4: A write to the control word (offset 0x000) with bit 1 (run) set raises run_req_o for that channel for exactly the one cycle after the write. On the same clock edge it loads the executing registers from the staged ones.
- R5: Interrupt output 2N is high exactly while control bit 14 (done enable) and bit 30 (done status) of channel N are both set.
- R6: Interrupt output 2N+1 is high exactly while control bit 15 (error enable) and bit 31 (error status) of channel N are both set.
- R7: A pulse on eng_done_i[N] sets bit 30 and clears bit 1 of channel N's control word. A pulse on eng_err_i[N] sets bit 31 and clears bit 1.
- R8: When an engine pulse and a software control write land in the same cycle, the pulse's updates to bits 30, 31 and 1 win over the written value.
- R9: Address bits [11:0] select the register and the bits above them select the channel. A channel number at or beyond the implemented count reads as zero, and writes to it change no register.
- R10: Unmapped or unaligned offsets inside a valid window read as zero. Control bits other than 0, 1, 14, 15, 30 and 31 read as zero.
- R11: req_ready_o is always high. rsp_valid_o is high exactly in the cycle after an accepted read, and it carries that read's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | AW | Byte address: channel above bit 11, register offset below |
| req_wdata_i | input | 32 | Write data |
| req_ready_o | output | 1 | Request accepted (always high) |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| eng_done_i | input | NCH | Per-channel transfer-complete pulse from the engine |
| eng_err_i | input | NCH | Per-channel transfer-error pulse from the engine |
| run_req_o | output | NCH | Per-channel start request, one cycle |
| exec_cfg_o | output | NCH*32 | Executing config, channel N at [N*32 +: 32] |
| exec_bytes_o | output | NCH*64 | Executing byte count, channel N at [N*64 +: 64] |
| exec_dst_o | output | NCH*64 | Executing destination address |
| exec_src_o | output | NCH*64 | Executing source address |
| irq_o | output | 2*NCH | Level interrupts: 2N done, 2N+1 error |

## Verification
The hardest case to reach is a software control write and an engine status pulse that arrive on the same clock edge. In normal use the engine answers long after the start write, so the two rarely meet. The bench forces the meeting by driving the control write and eng_done_i on the same falling edge. It then reads the control word and checks that the status bit is set and the run bit is clear even though the written value said otherwise. It also checks that the done interrupt follows the enable bit carried in that same write.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int unsigned WIN_BITS = 12;

  localparam int unsigned CTRL_CLAIM   = 0;
  localparam int unsigned CTRL_RUN     = 1;
  localparam int unsigned CTRL_DONE_IE = 14;
  localparam int unsigned CTRL_ERR_IE  = 15;
  localparam int unsigned CTRL_DONE    = 30;
  localparam int unsigned CTRL_ERR     = 31;

  localparam logic [31:0] CTRL_MASK = (32'd1 << CTRL_CLAIM) | (32'd1 << CTRL_RUN)
                                    | (32'd1 << CTRL_DONE_IE) | (32'd1 << CTRL_ERR_IE)
                                    | (32'd1 << CTRL_DONE) | (32'd1 << CTRL_ERR);

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_NCFG,
    SEL_NBYTES_LO, SEL_NBYTES_HI,
    SEL_NDST_LO,   SEL_NDST_HI,
    SEL_NSRC_LO,   SEL_NSRC_HI,
    SEL_XCFG,
    SEL_XBYTES_LO, SEL_XBYTES_HI,
    SEL_XDST_LO,   SEL_XDST_HI,
    SEL_XSRC_LO,   SEL_XSRC_HI
  } reg_sel_e;

  function automatic reg_sel_e decode_off(input logic [WIN_BITS-1:0] off);
    case (off)
      12'h000: decode_off = SEL_CTRL;
      12'h004: decode_off = SEL_NCFG;
      12'h008: decode_off = SEL_NBYTES_LO;
      12'h00C: decode_off = SEL_NBYTES_HI;
      12'h010: decode_off = SEL_NDST_LO;
      12'h014: decode_off = SEL_NDST_HI;
      12'h018: decode_off = SEL_NSRC_LO;
      12'h01C: decode_off = SEL_NSRC_HI;
      12'h104: decode_off = SEL_XCFG;
      12'h108: decode_off = SEL_XBYTES_LO;
      12'h10C: decode_off = SEL_XBYTES_HI;
      12'h110: decode_off = SEL_XDST_LO;
      12'h114: decode_off = SEL_XDST_HI;
      12'h118: decode_off = SEL_XSRC_LO;
      12'h11C: decode_off = SEL_XSRC_HI;
      default: decode_off = SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_dec.sv
module dma_addr_dec
  import dma_regs_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned NCH = 2,
  localparam int unsigned CHW = AW - WIN_BITS
) (
  input  logic [AW-1:0]  addr_i,
  output logic [CHW-1:0] ch_o,
  output logic           ch_ok_o,
  output reg_sel_e       sel_o
);

  always_comb begin
    ch_o    = addr_i[AW-1:WIN_BITS];
    ch_ok_o = (32'(ch_o) < NCH);
    sel_o   = decode_off(addr_i[WIN_BITS-1:0]);
  end

endmodule

// File: rtl/dma_chan_file.sv
module dma_chan_file
  import dma_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  reg_sel_e    sel_i,
  input  logic [31:0] wdata_i,
  input  logic        eng_done_i,
  input  logic        eng_err_i,
  output logic [31:0] rdata_o,
  output logic        run_req_o,
  output logic        done_o,
  output logic        err_o,
  output logic        done_ie_o,
  output logic        err_ie_o,
  output logic [31:0] xcfg_o,
  output logic [63:0] xbytes_o,
  output logic [63:0] xdst_o,
  output logic [63:0] xsrc_o
);

  logic [31:0] ctrl_q, ctrl_d, ncfg_q, xcfg_q;
  logic [63:0] nbytes_q, ndst_q, nsrc_q, xbytes_q, xdst_q, xsrc_q;
  logic        run_req_q;
  logic        ctrl_wr, start;

  assign ctrl_wr = wr_i && (sel_i == SEL_CTRL);
  assign start   = ctrl_wr && wdata_i[CTRL_RUN];

  // engine status overrides a same-cycle software write
  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) ctrl_d = wdata_i & CTRL_MASK;
    if (eng_done_i) begin
      ctrl_d[CTRL_DONE] = 1'b1;
      ctrl_d[CTRL_RUN]  = 1'b0;
    end
    if (eng_err_i) begin
      ctrl_d[CTRL_ERR] = 1'b1;
      ctrl_d[CTRL_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      ncfg_q    <= '0;
      nbytes_q  <= '0;
      ndst_q    <= '0;
      nsrc_q    <= '0;
      xcfg_q    <= '0;
      xbytes_q  <= '0;
      xdst_q    <= '0;
      xsrc_q    <= '0;
      run_req_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      run_req_q <= start;
      if (start) begin
        xcfg_q   <= ncfg_q;
        xbytes_q <= nbytes_q;
        xdst_q   <= ndst_q;
        xsrc_q   <= nsrc_q;
      end
      if (wr_i) begin
        case (sel_i)
          SEL_NCFG:      ncfg_q         <= wdata_i;
          SEL_NBYTES_LO: nbytes_q[31:0] <= wdata_i;
          SEL_NBYTES_HI: nbytes_q[63:32] <= wdata_i;
          SEL_NDST_LO:   ndst_q[31:0]   <= wdata_i;
          SEL_NDST_HI:   ndst_q[63:32]  <= wdata_i;
          SEL_NSRC_LO:   nsrc_q[31:0]   <= wdata_i;
          SEL_NSRC_HI:   nsrc_q[63:32]  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel_i)
      SEL_CTRL:      rdata_o = ctrl_q;
      SEL_NCFG:      rdata_o = ncfg_q;
      SEL_NBYTES_LO: rdata_o = nbytes_q[31:0];
      SEL_NBYTES_HI: rdata_o = nbytes_q[63:32];
      SEL_NDST_LO:   rdata_o = ndst_q[31:0];
      SEL_NDST_HI:   rdata_o = ndst_q[63:32];
      SEL_NSRC_LO:   rdata_o = nsrc_q[31:0];
      SEL_NSRC_HI:   rdata_o = nsrc_q[63:32];
      SEL_XCFG:      rdata_o = xcfg_q;
      SEL_XBYTES_LO: rdata_o = xbytes_q[31:0];
      SEL_XBYTES_HI: rdata_o = xbytes_q[63:32];
      SEL_XDST_LO:   rdata_o = xdst_q[31:0];
      SEL_XDST_HI:   rdata_o = xdst_q[63:32];
      SEL_XSRC_LO:   rdata_o = xsrc_q[31:0];
      SEL_XSRC_HI:   rdata_o = xsrc_q[63:32];
      default:       rdata_o = '0;
    endcase
  end

  assign run_req_o = run_req_q;
  assign done_o    = ctrl_q[CTRL_DONE];
  assign err_o     = ctrl_q[CTRL_ERR];
  assign done_ie_o = ctrl_q[CTRL_DONE_IE];
  assign err_ie_o  = ctrl_q[CTRL_ERR_IE];
  assign xcfg_o    = xcfg_q;
  assign xbytes_o  = xbytes_q;
  assign xdst_o    = xdst_q;
  assign xsrc_o    = xsrc_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned NCH = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic [AW-1:0]       req_addr_i,
  input  logic [31:0]         req_wdata_i,
  output logic                req_ready_o,
  output logic                rsp_valid_o,
  output logic [31:0]         rsp_rdata_o,
  input  logic [NCH-1:0]      eng_done_i,
  input  logic [NCH-1:0]      eng_err_i,
  output logic [NCH-1:0]      run_req_o,
  output logic [NCH*32-1:0]   exec_cfg_o,
  output logic [NCH*64-1:0]   exec_bytes_o,
  output logic [NCH*64-1:0]   exec_dst_o,
  output logic [NCH*64-1:0]   exec_src_o,
  output logic [2*NCH-1:0]    irq_o
);

  localparam int unsigned CHW = AW - WIN_BITS;

  logic [CHW-1:0] ch;
  logic           ch_ok;
  reg_sel_e       sel;
  logic [31:0]    ch_rdata [NCH];
  logic [31:0]    rd_mux;
  logic [NCH-1:0] done_st, err_st, done_ie, err_ie;
  logic           rsp_valid_q;
  logic [31:0]    rsp_rdata_q;

  dma_addr_dec #(.AW(AW), .NCH(NCH)) u_dec (
    .addr_i  (req_addr_i),
    .ch_o    (ch),
    .ch_ok_o (ch_ok),
    .sel_o   (sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = ch_ok && (ch == CHW'(c));

    dma_chan_file u_file (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (req_valid_i && req_write_i && hit),
      .sel_i      (sel),
      .wdata_i    (req_wdata_i),
      .eng_done_i (eng_done_i[c]),
      .eng_err_i  (eng_err_i[c]),
      .rdata_o    (ch_rdata[c]),
      .run_req_o  (run_req_o[c]),
      .done_o     (done_st[c]),
      .err_o      (err_st[c]),
      .done_ie_o  (done_ie[c]),
      .err_ie_o   (err_ie[c]),
      .xcfg_o     (exec_cfg_o[c*32 +: 32]),
      .xbytes_o   (exec_bytes_o[c*64 +: 64]),
      .xdst_o     (exec_dst_o[c*64 +: 64]),
      .xsrc_o     (exec_src_o[c*64 +: 64])
    );

    assign irq_o[2*c]   = done_ie[c] && done_st[c];
    assign irq_o[2*c+1] = err_ie[c] && err_st[c];
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_ok && (ch == CHW'(i))) rd_mux = ch_rdata[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i) rsp_rdata_q <= rd_mux;
    end
  end

  assign req_ready_o = 1'b1;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned AW  = 16,
  parameter int unsigned NCH = 2,
  localparam int unsigned CHW = AW - 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [AW-1:0]     req_addr_i,
  input logic              rsp_valid_o,
  input logic [NCH-1:0]    eng_done_i,
  input logic [NCH-1:0]    eng_err_i,
  input logic [NCH-1:0]    run_req_o,
  input logic [NCH*64-1:0] exec_bytes_o,
  input logic [2*NCH-1:0]  irq_o,
  input logic [NCH-1:0]    done_st,
  input logic [NCH-1:0]    err_st
);

  AST_RSP_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o) else $error("rsp missing"); // R11
  AST_NO_STRAY_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o) else $error("stray rsp"); // R11

  for (genvar n = 0; n < NCH; n++) begin : g_chk
    AST_RUN_FROM_CTRL_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_req_o[n] |-> $past(req_valid_i && req_write_i && (req_addr_i == {CHW'(n), 12'h000})))
      else $error("run_req without control write"); // R4
    AST_EXEC_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_req_o[n] |-> $stable(exec_bytes_o[n*64 +: 64])) else $error("exec changed"); // R3
    AST_DONE_PULSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_done_i[n] |=> done_st[n]) else $error("done not set"); // R7 R8
    AST_ERR_PULSE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eng_err_i[n] |=> err_st[n]) else $error("err not set"); // R7 R8
    AST_DONE_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[2*n] |-> done_st[n]) else $error("done irq without status"); // R5
    AST_ERR_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[2*n+1] |-> err_st[n]) else $error("err irq without status"); // R6
  end

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.AW(AW), .NCH(NCH)) u_chk (.*);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;

  localparam int AW  = 16;
  localparam int NCH = 2;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_write_i = 1'b0;
  logic [AW-1:0]     req_addr_i = '0;
  logic [31:0]       req_wdata_i = '0;
  logic              req_ready_o, rsp_valid_o;
  logic [31:0]       rsp_rdata_o;
  logic [NCH-1:0]    eng_done_i = '0;
  logic [NCH-1:0]    eng_err_i = '0;
  logic [NCH-1:0]    run_req_o;
  logic [NCH*32-1:0] exec_cfg_o;
  logic [NCH*64-1:0] exec_bytes_o, exec_dst_o, exec_src_o;
  logic [2*NCH-1:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dma_chan_regs #(.AW(AW), .NCH(NCH)) u_dma_chan_regs (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o),
    .eng_done_i(eng_done_i), .eng_err_i(eng_err_i), .run_req_o(run_req_o),
    .exec_cfg_o(exec_cfg_o), .exec_bytes_o(exec_bytes_o),
    .exec_dst_o(exec_dst_o), .exec_src_o(exec_src_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a;
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R11 rsp_valid", 64'(rsp_valid_o), 64'd1);
    d = rsp_rdata_o;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, 64'(d), 64'(exp));
  endtask

  task automatic t_reset;
    check("R1 irq", 64'(irq_o), 64'd0);
    check("R1 run_req", 64'(run_req_o), 64'd0);
    check("R11 ready", 64'(req_ready_o), 64'd1);
    rd_chk("R1 ctrl ch0", 16'h0000, 32'h0);
    rd_chk("R1 next cfg ch1", 16'h1004, 32'h0);
    rd_chk("R1 exec src ch0", 16'h0118, 32'h0);
  endtask

  task automatic t_next_rw;
    wr(16'h0004, 32'h6600_000C);
    wr(16'h0008, 32'h0000_0040);
    wr(16'h000C, 32'h0000_0001);
    wr(16'h0010, 32'h8000_1000);
    wr(16'h0014, 32'h0000_0002);
    wr(16'h0018, 32'h8000_2000);
    wr(16'h001C, 32'h0000_0003);
    check("R11 no rsp after write", 64'(rsp_valid_o), 64'd0);
    rd_chk("R2 next cfg", 16'h0004, 32'h6600_000C);
    rd_chk("R2 bytes lo", 16'h0008, 32'h0000_0040);
    rd_chk("R2 bytes hi", 16'h000C, 32'h0000_0001);
    rd_chk("R2 dst lo", 16'h0010, 32'h8000_1000);
    rd_chk("R2 dst hi", 16'h0014, 32'h0000_0002);
    rd_chk("R2 src lo", 16'h0018, 32'h8000_2000);
    rd_chk("R2 src hi", 16'h001C, 32'h0000_0003);
  endtask

  task automatic t_exec_ro;
    wr(16'h0104, 32'hDEAD_BEEF);
    wr(16'h0108, 32'h1234_5678);
    wr(16'h0114, 32'hFFFF_FFFF);
    rd_chk("R3 exec cfg ro", 16'h0104, 32'h0);
    rd_chk("R3 exec bytes ro", 16'h0108, 32'h0);
    rd_chk("R3 exec dst hi ro", 16'h0114, 32'h0);
    check("R3 exec bytes port", exec_bytes_o[63:0], 64'h0);
  endtask

  task automatic t_start;
    wr(16'h0000, 32'h0000_0002);
    check("R4 run_req pulse", 64'(run_req_o), 64'b01);
    check("R4 exec bytes port", exec_bytes_o[63:0], 64'h0000_0001_0000_0040);
    check("R4 exec dst port", exec_dst_o[63:0], 64'h0000_0002_8000_1000);
    check("R4 exec src port", exec_src_o[63:0], 64'h0000_0003_8000_2000);
    check("R4 exec cfg port", 64'(exec_cfg_o[31:0]), 64'h6600_000C);
    @(negedge clk);
    check("R4 run_req one cycle", 64'(run_req_o), 64'b00);
    rd_chk("R4 exec cfg read", 16'h0104, 32'h6600_000C);
    rd_chk("R4 exec bytes hi read", 16'h010C, 32'h0000_0001);
    rd_chk("R4 exec src lo read", 16'h0118, 32'h8000_2000);
    rd_chk("R4 ctrl run held", 16'h0000, 32'h0000_0002);
  endtask

  task automatic t_done_irq;
    @(negedge clk); eng_done_i = 2'b01;
    @(negedge clk); eng_done_i = 2'b00;
    rd_chk("R7 done sets, run clears", 16'h0000, 32'h4000_0000);
    check("R5 no irq without enable", 64'(irq_o), 64'd0);
    wr(16'h0000, 32'h4000_4000);
    check("R5 done irq high", 64'(irq_o), 64'b0001);
    wr(16'h0000, 32'h0000_4000);
    check("R5 done irq low after clear", 64'(irq_o), 64'b0000);
  endtask

  task automatic t_err_irq;
    wr(16'h1000, 32'h0000_8002);
    check("R4 ch1 run_req", 64'(run_req_o), 64'b10);
    @(negedge clk); eng_err_i = 2'b10;
    @(negedge clk); eng_err_i = 2'b00;
    rd_chk("R7 err sets, run clears", 16'h1000, 32'h8000_8000);
    check("R6 err irq ch1", 64'(irq_o), 64'b1000);
    wr(16'h1000, 32'h8000_0000);
    check("R6 err irq needs enable", 64'(irq_o), 64'b0000);
  endtask

  task automatic t_priority;
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 16'h0000; req_wdata_i = 32'h0000_4002;
    eng_done_i = 2'b01;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0; eng_done_i = 2'b00;
    rd_chk("R8 status wins over write", 16'h0000, 32'h4000_4000);
    check("R8 done irq after collision", 64'(irq_o), 64'b0001);
  endtask

  task automatic t_range;
    wr(16'h2008, 32'hAAAA_5555);
    wr(16'h2000, 32'h0000_C002);
    check("R9 no run_req for bad channel", 64'(run_req_o), 64'b00);
    rd_chk("R9 bad channel reads zero", 16'h2008, 32'h0);
    rd_chk("R9 ch0 untouched", 16'h0008, 32'h0000_0040);
    rd_chk("R9 ch0 ctrl untouched", 16'h0000, 32'h4000_4000);
  endtask

  task automatic t_unmapped;
    rd_chk("R10 unmapped offset", 16'h0020, 32'h0);
    rd_chk("R10 unaligned offset", 16'h0006, 32'h0);
    wr(16'h1000, 32'hFFFF_FFFF);
    rd_chk("R10 ctrl undefined bits zero", 16'h1000, 32'hC000_C003);
    check("R5 R6 both irqs ch1", 64'(irq_o), 64'b1101);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_next_rw();
    t_exec_ro();
    t_start();
    t_done_irq();
    t_err_irq();
    t_priority();
    t_range();
    t_unmapped();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule